// File: doc/BRIEF.md
# Segment Access Fault Classifier

This block judges a single memory operand reference against the descriptor data of the segment that the reference goes through, and reports which exception vector the reference raises, if any. The request gives the operating mode (real or protected), the segment register in use, the first byte offset, the byte count, the segment limit, the descriptor's present bit, a permission verdict from the access-rights logic, and a flag that marks the reference as the target of a control transfer.

Each request strobe produces a result one clock later: a fault flag and an 8-bit vector number. The result stays on the outputs until the next strobe, so a dispatch stage can sample it whenever it is ready. A stack-segment problem reports vector 12, and other segments report 13 or 11. A reference whose first byte is inside the limit but whose last byte is past it still faults. Descriptor fetch, paging and the dispatch of the exception are handled elsewhere.

Top module: `segchk_top`

## Requirements
- R1: The outputs `fault_valid` and `fault_vec` change only on the clock edge that samples `req` high, and they take the result for the inputs sampled on that edge. They hold their value while `req` is low.
- R2: The last byte of a reference is `offset + size - 1`, and a `size` of 0 counts as one byte. The reference violates the limit when its last byte is above the effective limit. A last byte equal to the limit is allowed, and a reference that starts inside the limit and ends past it violates.
- R3: A reference whose last byte would wrap past the top of the `ADDR_W`-bit address space is a limit violation.
- R4: `seg_sel` is encoded as 0=CS, 1=DS, 2=ES, 3=FS, 4=GS, 5=SS. Codes 6 and 7 are treated as data segments. A limit violation reports vector 12 for SS and vector 13 for all other segments.
- R5: In protected mode, when `present` is 0 the block reports vector 11 for a non-stack segment and vector 12 for SS.
- R6: In protected mode, when `rights_ok` is 0 the block reports vector 13 for any segment.
- R7: When several faults apply at once, the not-present fault wins over the limit fault, and the limit fault wins over the rights fault. Only one vector is reported.
- R8: In protected mode, when `xfer_tgt` is 1 a limit violation reports vector 13 whatever `seg_sel` is.
- R9: In real mode (`prot_mode` = 0), the limit is the parameter `REAL_LIMIT` (default 0xFFFF) and the `limit` input is ignored. `present`, `rights_ok` and `xfer_tgt` have no effect, and the SS=12 / other=13 split still applies.
- R10: A synchronous active-high `rst` clears `fault_valid` and `fault_vec` to 0. Whenever `fault_valid` is 0, `fault_vec` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Request strobe; inputs are sampled when high |
| prot_mode | input | 1 | 1 = protected mode, 0 = real mode |
| seg_sel | input | 3 | Segment register in use (encoding in R4) |
| offset | input | ADDR_W | Offset of the first byte |
| size | input | SIZE_W | Byte count of the reference |
| limit | input | ADDR_W | Segment limit (highest valid offset) |
| present | input | 1 | Descriptor present bit |
| rights_ok | input | 1 | Access-rights check passed |
| xfer_tgt | input | 1 | Reference is a control-transfer target |
| fault_valid | output | 1 | A fault results from the last request |
| fault_vec | output | 8 | Exception vector (11, 12 or 13), 0 when no fault |

## Verification
The bench targets these corner cases:
- A last byte exactly on the limit must pass, and one byte more must fault. An off-by-one end calculation fails one of these two cases.
- An offset near the top of the address space must wrap and fault. A design without the carry bit would pass this reference.
- Cases that combine not-present, over-limit and bad-rights check the priority order. A wrong order shows up as vector 13 where 11 or 12 is expected.
- Real-mode references use a tiny `limit` input together with a cleared present bit. They catch a design that reads descriptor data in real mode.
- A stack reference that is a control-transfer target checks that it reports 13, not 12.
- Input changes without a strobe check that the held outputs do not move.

// File: rtl/segchk_pkg.sv
package segchk_pkg;

    typedef enum logic [2:0] {
        SEG_CS  = 3'd0,
        SEG_DS  = 3'd1,
        SEG_ES  = 3'd2,
        SEG_FS  = 3'd3,
        SEG_GS  = 3'd4,
        SEG_SS  = 3'd5,
        SEG_RS6 = 3'd6,
        SEG_RS7 = 3'd7
    } seg_e;

    localparam logic [7:0] VEC_NONE    = 8'd0;
    localparam logic [7:0] VEC_ABSENT  = 8'd11;
    localparam logic [7:0] VEC_STACK   = 8'd12;
    localparam logic [7:0] VEC_GENPROT = 8'd13;

    typedef struct packed {
        logic       valid;
        logic [7:0] vec;
    } verdict_t;

endpackage

// File: rtl/segchk_span.sv
module segchk_span #(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 4
) (
    input  logic [ADDR_W-1:0] offset,
    input  logic [SIZE_W-1:0] size,
    input  logic [ADDR_W-1:0] bound,
    output logic              over
);
    localparam int EXT_W = ADDR_W + 1;

    logic [SIZE_W-1:0] size_eff;
    logic [EXT_W-1:0]  last_byte;

    always_comb begin
        size_eff  = (size == '0) ? SIZE_W'(1) : size;
        last_byte = {1'b0, offset} + EXT_W'(size_eff) - EXT_W'(1);
        over      = last_byte[ADDR_W] | (last_byte[ADDR_W-1:0] > bound);
    end

endmodule

// File: rtl/segchk_resolve.sv
module segchk_resolve
    import segchk_pkg::*;
(
    input  logic       prot_mode,
    input  seg_e       seg,
    input  logic       present,
    input  logic       rights_ok,
    input  logic       xfer_tgt,
    input  logic       over,
    output verdict_t   verdict
);
    logic is_stack;

    always_comb begin
        is_stack = (seg == SEG_SS);
        verdict  = '{valid: 1'b0, vec: VEC_NONE};
        if (prot_mode) begin
            if (!present) begin
                verdict = '{valid: 1'b1, vec: is_stack ? VEC_STACK : VEC_ABSENT};
            end else if (over) begin
                verdict = '{valid: 1'b1,
                            vec: (is_stack && !xfer_tgt) ? VEC_STACK : VEC_GENPROT};
            end else if (!rights_ok) begin
                verdict = '{valid: 1'b1, vec: VEC_GENPROT};
            end
        end else if (over) begin
            verdict = '{valid: 1'b1, vec: is_stack ? VEC_STACK : VEC_GENPROT};
        end
    end

endmodule

// File: rtl/segchk_top.sv
module segchk_top
    import segchk_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                SIZE_W     = 4,
    parameter logic [ADDR_W-1:0] REAL_LIMIT = ADDR_W'(32'h0000_FFFF)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              prot_mode,
    input  logic [2:0]        seg_sel,
    input  logic [ADDR_W-1:0] offset,
    input  logic [SIZE_W-1:0] size,
    input  logic [ADDR_W-1:0] limit,
    input  logic              present,
    input  logic              rights_ok,
    input  logic              xfer_tgt,
    output logic              fault_valid,
    output logic [7:0]        fault_vec
);
    logic [ADDR_W-1:0] eff_limit;
    logic              over;
    verdict_t          verdict;
    verdict_t          res_d;
    verdict_t          res_q;

    assign eff_limit = prot_mode ? limit : REAL_LIMIT;

    segchk_span #(
        .ADDR_W (ADDR_W),
        .SIZE_W (SIZE_W)
    ) u_span (
        .offset (offset),
        .size   (size),
        .bound  (eff_limit),
        .over   (over)
    );

    segchk_resolve u_resolve (
        .prot_mode (prot_mode),
        .seg       (seg_e'(seg_sel)),
        .present   (present),
        .rights_ok (rights_ok),
        .xfer_tgt  (xfer_tgt),
        .over      (over),
        .verdict   (verdict)
    );

    always_comb begin
        res_d = res_q;
        if (req) begin
            res_d = verdict;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '{valid: 1'b0, vec: VEC_NONE};
        end else begin
            res_q <= res_d;
        end
    end

    assign fault_valid = res_q.valid;
    assign fault_vec   = res_q.vec;

endmodule

// File: rtl/segchk_checker.sv
module segchk_checker (
    input logic       clk,
    input logic       rst,
    input logic       req,
    input logic       prot_mode,
    input logic [2:0] seg_sel,
    input logic       present,
    input logic       fault_valid,
    input logic [7:0] fault_vec
);

    a_r10_reset_clear: assert property (@(posedge clk)
        rst |=> (!fault_valid && fault_vec == 8'd0));

    a_r10_quiet_zero: assert property (@(posedge clk) disable iff (rst)
        !fault_valid |-> fault_vec == 8'd0);

    a_r1_hold: assert property (@(posedge clk) disable iff (rst)
        !req |=> ($stable(fault_valid) && $stable(fault_vec)));

    a_r4_vec_range: assert property (@(posedge clk) disable iff (rst)
        fault_valid |-> (fault_vec == 8'd11 || fault_vec == 8'd12 || fault_vec == 8'd13));

    a_r5_absent: assert property (@(posedge clk) disable iff (rst)
        (req && prot_mode && !present) |=>
            (fault_valid && (fault_vec == 8'd11 || fault_vec == 8'd12)));

    a_r9_real_stack: assert property (@(posedge clk) disable iff (rst)
        (req && !prot_mode && seg_sel == 3'd5) |=> (!fault_valid || fault_vec == 8'd12));

endmodule

bind segchk_top segchk_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .req         (req),
    .prot_mode   (prot_mode),
    .seg_sel     (seg_sel),
    .present     (present),
    .fault_valid (fault_valid),
    .fault_vec   (fault_vec)
);

// File: tb/segchk_top_tb.sv
module segchk_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        prot_mode = 1'b1;
    logic [2:0]  seg_sel = 3'd1;
    logic [31:0] offset = '0;
    logic [3:0]  size = 4'd1;
    logic [31:0] limit = 32'hFFFF_FFFF;
    logic        present = 1'b1;
    logic        rights_ok = 1'b1;
    logic        xfer_tgt = 1'b0;
    logic        fault_valid;
    logic [7:0]  fault_vec;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [8:0] exp_q[$];
    string      tag_q[$];
    logic [8:0] last_exp = '0;

    always #4 clk = ~clk;

    segchk_top u_dut (
        .clk (clk), .rst (rst), .req (req), .prot_mode (prot_mode),
        .seg_sel (seg_sel), .offset (offset), .size (size), .limit (limit),
        .present (present), .rights_ok (rights_ok), .xfer_tgt (xfer_tgt),
        .fault_valid (fault_valid), .fault_vec (fault_vec)
    );

    function automatic logic [8:0] model(input logic pm, input logic [2:0] sg,
                                         input logic [31:0] off, input logic [3:0] sz,
                                         input logic [31:0] lim, input logic pr,
                                         input logic rk, input logic xf);
        longint unsigned n    = (sz == 0) ? 1 : longint'(sz);
        longint unsigned last = longint'(off) + n - 1;
        longint unsigned top  = pm ? longint'(lim) : 64'h0000_FFFF;
        bit stk = (sg == 3'd5);
        bit ovr = (last > 64'hFFFF_FFFF) || (last > top);
        if (!pm) return ovr ? {1'b1, stk ? 8'd12 : 8'd13} : 9'd0;
        if (!pr) return {1'b1, stk ? 8'd12 : 8'd11};
        if (ovr) return {1'b1, (stk && !xf) ? 8'd12 : 8'd13};
        if (!rk) return {1'b1, 8'd13};
        return 9'd0;
    endfunction

    task automatic compare(input logic [8:0] exp, input string tag);
        n_checks++;
        if ({fault_valid, fault_vec} !== exp) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b vec=%0d, expected valid=%0b vec=%0d",
                     tag, fault_valid, fault_vec, exp[8], exp[7:0]);
        end
    endtask

    task automatic send(input string tag, input logic pm, input logic [2:0] sg,
                        input logic [31:0] off, input logic [3:0] sz,
                        input logic [31:0] lim, input logic pr, input logic rk,
                        input logic xf);
        @(negedge clk);
        prot_mode = pm; seg_sel = sg; offset = off; size = sz; limit = lim;
        present = pr; rights_ok = rk; xfer_tgt = xf; req = 1'b1;
        exp_q.push_back(model(pm, sg, off, sz, lim, pr, rk, xf));
        tag_q.push_back(tag);
        @(negedge clk);
        req = 1'b0;
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            if (req && !rst) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    n_checks++; n_fail++;
                    $display("FAIL R1: result with no expected item");
                end else begin
                    last_exp = exp_q.pop_front();
                    compare(last_exp, tag_q.pop_front());
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        compare(9'd0, "R10 reset state");
        rst = 1'b0;

        send("R2 inside limit",        1, 3'd1, 32'h100, 4'd4, 32'h1FF, 1, 1, 0);
        send("R2 end on limit",        1, 3'd1, 32'h1FC, 4'd4, 32'h1FF, 1, 1, 0);
        send("R2 partial cross DS",    1, 3'd1, 32'h1FE, 4'd4, 32'h1FF, 1, 1, 0);
        send("R4 partial cross SS",    1, 3'd5, 32'h1FE, 4'd4, 32'h1FF, 1, 1, 0);
        send("R4 cross via code 7",    1, 3'd7, 32'h200, 4'd1, 32'h1FF, 1, 1, 0);
        send("R2 size zero on limit",  1, 3'd2, 32'h1FF, 4'd0, 32'h1FF, 1, 1, 0);
        send("R3 wrap past top",       1, 3'd3, 32'hFFFF_FFFE, 4'd4, 32'hFFFF_FFFF, 1, 1, 0);
        send("R5 absent DS",           1, 3'd1, 32'h0, 4'd1, 32'hFF, 0, 1, 0);
        send("R5 absent SS",           1, 3'd5, 32'h0, 4'd1, 32'hFF, 0, 1, 0);
        send("R6 rights bad GS",       1, 3'd4, 32'h10, 4'd2, 32'hFF, 1, 0, 0);
        send("R6 rights bad SS",       1, 3'd5, 32'h10, 4'd2, 32'hFF, 1, 0, 0);
        send("R7 absent over limit",   1, 3'd1, 32'h400, 4'd8, 32'hFF, 0, 0, 0);
        send("R7 limit over rights SS",1, 3'd5, 32'h400, 4'd8, 32'hFF, 1, 0, 0);
        send("R8 target past CS",      1, 3'd0, 32'h1000, 4'd1, 32'hFFF, 1, 1, 1);
        send("R8 target via SS",       1, 3'd5, 32'h1000, 4'd1, 32'hFFF, 1, 1, 1);
        send("R9 real ignores limit",  0, 3'd1, 32'h100, 4'd2, 32'h10, 0, 0, 1);
        send("R9 real cross DS",       0, 3'd1, 32'hFFFF, 4'd2, 32'hFFFF_FFFF, 1, 1, 0);
        send("R9 real cross SS",       0, 3'd5, 32'hFFFE, 4'd4, 32'hFFFF_FFFF, 1, 1, 1);
        send("R9 real end at max",     0, 3'd5, 32'hFFFC, 4'd4, 32'h0, 0, 0, 0);

        send("R1 setup fault",         1, 3'd5, 32'h0, 4'd1, 32'hFF, 0, 1, 0);
        @(negedge clk);
        prot_mode = 1; seg_sel = 3'd1; present = 1; rights_ok = 1; offset = 0; limit = 32'hFF;
        repeat (3) @(negedge clk);
        compare(last_exp, "R1 hold without strobe");

        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        compare(9'd0, "R10 reset clears fault");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule